// File: doc/BRIEF.md
# Dual-Path Reset Release Sequencer

This block produces the reset controls for one clock domain from a single active-low reset pin. It has two reset paths. The first is an asynchronous reset that follows the pin directly, on assertion and on release, with no synchronizer in the way. The second is a synchronous reset that stays asserted for a programmable number of clock cycles after the pin lets go. The flops it drives therefore hold their data inputs at the reset value until their asynchronous reset is well past its recovery window. The delay also covers a reset transport delay that spans several clocks across a large die.

The synchronous reset is spread through a tree of registered stages. Each stage drives only a few registers of the next stage, which keeps fanout small at every level. The leaves of the tree go to the target flops. Every leaf releases on the same clock edge. A state register that starts at zero therefore leaves zero with all of its bits released together. A ready flag rises on the edge where the leaves release. If the pin asserts again at any point, the whole sequence returns to reset at once and the ready flag drops.

Top module: `rst_release_seq`

## Requirements
- R1: `arst_n_o` equals `rst_pin_n` at all times, on both edges of the pin, without waiting for a clock edge.
- R2: While `rst_pin_n` is 0, every bit of `srst_o` is 1 (asserted) and `ready_o` is 0.
- R3: The edges are numbered from 1, starting at the first rising clock edge after `rst_pin_n` rises. `srst_o` stays all ones through edge RELEASE_CYCLES+STAGES-1 and becomes all zeros at edge RELEASE_CYCLES+STAGES. The moment of release within the clock period does not change this.
- R4: All bits of `srst_o` (BRANCH^(STAGES-1) leaves) change on the same edge, so `srst_o` is never a mix of ones and zeros.
- R5: If `rst_pin_n` falls at any point in the release sequence, `srst_o` returns to all ones and `ready_o` to 0 at once, without a clock edge. The next release then counts the full RELEASE_CYCLES+STAGES edges again.
- R6: `ready_o` rises on the same edge on which `srst_o` becomes all zeros, and `ready_o` is 1 exactly when `srst_o` is all zeros.
- R7: Once released, `srst_o` stays all zeros and `ready_o` stays 1 for as long as `rst_pin_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the reset domain |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| arst_n_o | output | 1 | Asynchronous reset to target flops, active low, follows the pin |
| srst_o | output | BRANCH^(STAGES-1) | Synchronous reset leaves, active high, one per target group |
| ready_o | output | 1 | High once the synchronous reset has been released |

## Verification
Suppose the delay counter loses or gains a count, or a cascade stage is skipped or doubled. Then the release edge moves away from RELEASE_CYCLES+STAGES, and the first sample after the expected edge shows it. A tree register that misses its async preset, or that is fed from the wrong parent, leaves `srst_o` mixed on some edge or slow to return on a mid-sequence abort. That shows within one clock of the event. A ready flop on the wrong stage leaves `ready_o` and `srst_o` out of step by a whole cycle at the release edge.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Number of register copies in cascade stage k when each register feeds `branch` children.
  function automatic int stage_width(input int branch, input int k);
    int w;
    w = 1;
    for (int i = 0; i < k; i++) w = w * branch;
    return w;
  endfunction

  // Edges from pin release to synchronous release of the leaves.
  function automatic int release_latency(input int cycles, input int stages);
    return cycles + stages;
  endfunction

  // Width of a counter that must hold values 0..limit.
  function automatic int count_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/rst_delay_counter.sv
module rst_delay_counter
  import rst_seq_pkg::*;
#(
  parameter int COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic hold_o
);
  localparam int CW = count_bits(COUNT);

  logic [CW-1:0] cnt;
  logic          done;

  assign done   = (cnt == CW'(COUNT));
  assign hold_o = ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (cnt - $past(cnt)) == CW'(1)); // R3

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(cnt))); // R3

endmodule

// File: rtl/rst_fanout_cascade.sv
module rst_fanout_cascade
  import rst_seq_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int BRANCH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic [stage_width(BRANCH, STAGES-1)-1:0] leaves_o,
  output logic ready_o
);
  localparam int LEAVES = stage_width(BRANCH, STAGES-1);

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int W = stage_width(BRANCH, k);
    logic [W-1:0] q;
    for (genvar i = 0; i < W; i++) begin : g_reg
      logic parent;
      if (k == 0) begin : g_root
        assign parent = hold_i;
      end else begin : g_child
        assign parent = g_stage[k-1].q[i / BRANCH];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b1;
        else        q[i] <= parent;
      end
    end
  end

  assign leaves_o = g_stage[STAGES-1].q;

  // Ready flop sits at leaf depth and shares the parent of leaf 0.
  logic ready_src;
  if (STAGES == 1) begin : g_rdy_root
    assign ready_src = hold_i;
  end else begin : g_rdy_child
    assign ready_src = g_stage[STAGES-2].q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_o <= 1'b0;
    else        ready_o <= ~ready_src;
  end

  AST_LEAVES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (leaves_o == '0) || (leaves_o == {LEAVES{1'b1}})); // R4

endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rst_seq_pkg::*;
#(
  parameter int RELEASE_CYCLES = 4,
  parameter int STAGES         = 2,
  parameter int BRANCH         = 4
) (
  input  logic clk,
  input  logic rst_pin_n,
  output logic arst_n_o,
  output logic [stage_width(BRANCH, STAGES-1)-1:0] srst_o,
  output logic ready_o
);
  localparam int LEAVES = stage_width(BRANCH, STAGES-1);
  localparam int LAT    = release_latency(RELEASE_CYCLES, STAGES);
  localparam int LW     = count_bits(LAT);

  // Asynchronous path: straight from the pin, both edges.
  assign arst_n_o = rst_pin_n;

  logic count_hold;

  rst_delay_counter #(
    .COUNT (RELEASE_CYCLES)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_pin_n),
    .hold_o (count_hold)
  );

  rst_fanout_cascade #(
    .STAGES (STAGES),
    .BRANCH (BRANCH)
  ) u_cascade (
    .clk      (clk),
    .rst_n    (rst_pin_n),
    .hold_i   (count_hold),
    .leaves_o (srst_o),
    .ready_o  (ready_o)
  );

  // Edge count since release, saturating at LAT; observation only.
  logic [LW-1:0] since_rel;
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n)                 since_rel <= '0;
    else if (since_rel != LW'(LAT)) since_rel <= since_rel + 1'b1;
  end

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (since_rel < LW'(LAT)) |-> (srst_o == {LEAVES{1'b1}})); // R3

  AST_RELEASE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(srst_o[0]) |-> (since_rel == LW'(LAT))); // R3

  AST_READY_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ready_o == (srst_o == '0)); // R6

  AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ready_o |=> (ready_o && srst_o == '0)); // R7

endmodule

// File: tb/rst_release_seq_test.sv
`timescale 1ns/1ps
module rst_release_seq_test;
  localparam int RC     = 4;
  localparam int ST     = 2;
  localparam int BR     = 4;
  localparam int LEAVES = BR ** (ST - 1);
  localparam int LAT    = RC + ST;
  localparam logic [LEAVES-1:0] ALL = {LEAVES{1'b1}};

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic arst_n_o;
  logic [LEAVES-1:0] srst_o;
  logic ready_o;

  int n_checks = 0;
  int n_fail   = 0;

  rst_release_seq #(.RELEASE_CYCLES(RC), .STAGES(ST), .BRANCH(BR)) uut (
    .clk       (clk),
    .rst_pin_n (rst_pin_n),
    .arst_n_o  (arst_n_o),
    .srst_o    (srst_o),
    .ready_o   (ready_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Release at `phase` ns after a rising edge, then check every edge up to LAT+2.
  task automatic run_release(input real phase, input string tag);
    @(posedge clk);
    #(phase);
    rst_pin_n = 1'b1;
    #0.25;
    check(arst_n_o == 1'b1, "R1 release", int'(arst_n_o), 1);
    for (int k = 1; k <= LAT + 2; k++) begin
      @(posedge clk);
      #1;
      check(srst_o == ((k < LAT) ? ALL : '0), tag, int'(srst_o), int'((k < LAT) ? ALL : '0));
      check(ready_o == (k >= LAT), "R6 ready edge", int'(ready_o), int'(k >= LAT));
      check(srst_o == '0 || srst_o == ALL, "R4 aligned", int'(srst_o), 0);
    end
  endtask

  task automatic pull_reset();
    #1.5;
    rst_pin_n = 1'b0;
    #0.25;
    check(arst_n_o == 1'b0, "R1 assert", int'(arst_n_o), 0);
    check(srst_o == ALL, "R5 abort srst", int'(srst_o), int'(ALL));
    check(ready_o == 1'b0, "R5 abort ready", int'(ready_o), 0);
  endtask

  initial begin
    #20;
    check(arst_n_o == 1'b0, "R1 reset", int'(arst_n_o), 0);
    check(srst_o == ALL, "R2 reset srst", int'(srst_o), int'(ALL));
    check(ready_o == 1'b0, "R2 reset ready", int'(ready_o), 0);

    // R3: sweep release phase across the clock period in half-ns steps.
    for (int h = 1; h < 16; h++) begin
      run_release(h * 0.5, "R3 latency");
      pull_reset();
      repeat (2) @(posedge clk);
      #1;
      check(srst_o == ALL && !ready_o, "R2 held low", int'(srst_o), int'(ALL));
    end

    // R5: abort after each possible number of edges, then a full restart.
    for (int j = 1; j < LAT; j++) begin
      @(posedge clk);
      #3;
      rst_pin_n = 1'b1;
      repeat (j) @(posedge clk);
      #1;
      check(ready_o == 1'b0, "R5 before abort", int'(ready_o), 0);
      pull_reset();
      repeat (3) @(posedge clk);
      run_release(2.0 + 0.5 * j, "R5 restart");
      pull_reset();
    end

    // R7: stay released for a long stretch.
    run_release(5.0, "R3 latency");
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      #1;
      check(srst_o == '0 && ready_o, "R7 hold", int'(srst_o), 0);
    end
    pull_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule